// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Controller

This block raises and clears the two port-to-port interrupt flags that sit beside a shared dual-port memory. It watches the chip enable, write enable, output enable and address of each port, plus a busy input per port from the contention arbiter. It stores no message data; the memory array holds the message.

The top two word addresses of the memory act as mailboxes. The all-ones address belongs to the right port, and the address one below it belongs to the left port. When one port writes into the other port's mailbox, the owner's active-low interrupt is driven low. When the owner reads its own mailbox, the interrupt is released. While a port's busy input is active, that port can neither post to its peer nor acknowledge its own flag. Everything is synchronous to one clock, and the address width is a parameter.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After a clock edge with `rst_n` low, both `lft_irq_n` and `rgt_irq_n` are 1.
- R2: The right port's mailbox is the all-ones address. The left port's mailbox is the all-ones address minus one. No other address sets or clears a flag.
- R3: A left write (`lft_en_n`=0, `lft_we_n`=0, `lft_busy_n`=1) to the right mailbox drives `rgt_irq_n` to 0 after that clock edge.
- R4: A right write (`rgt_en_n`=0, `rgt_we_n`=0, `rgt_busy_n`=1) to the left mailbox drives `lft_irq_n` to 0 after that clock edge.
- R5: A read by the owner of its own mailbox drives that port's flag to 1 after that clock edge. A read means `en_n`=0, `we_n`=1, `oe_n`=0 and `busy_n`=1.
- R6: A read of the opposite port's mailbox changes neither flag.
- R7: While a port's `busy_n` is 0, its write to the peer's mailbox does not set the peer's flag.
- R8: While a port's `busy_n` is 0, its read of its own mailbox does not clear its flag.
- R9: When a set and a clear reach the same flag on the same edge, the flag ends at 0.
- R10: These accesses leave both flags unchanged: an access with `en_n`=1, a read with `oe_n`=1, and a write by a port to its own mailbox.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lft_en_n | input | 1 | Left chip enable, active low |
| lft_we_n | input | 1 | Left write enable, active low (1 = read) |
| lft_oe_n | input | 1 | Left output enable, active low |
| lft_busy_n | input | 1 | Left busy from the arbiter, active low |
| lft_addr | input | AW | Left word address |
| rgt_en_n | input | 1 | Right chip enable, active low |
| rgt_we_n | input | 1 | Right write enable, active low (1 = read) |
| rgt_oe_n | input | 1 | Right output enable, active low |
| rgt_busy_n | input | 1 | Right busy from the arbiter, active low |
| rgt_addr | input | AW | Right word address |
| lft_irq_n | output | 1 | Left interrupt, active low |
| rgt_irq_n | output | 1 | Right interrupt, active low |

## Verification
The bench builds the block with `AW` = 4, so the mailboxes are at 15 and 14. With only sixteen addresses, every address can be swept as a write target from each port. The sweep includes address 13, directly below both mailboxes, and address 0, at the other end of the range. Using both ports in the same cycle reaches the simultaneous set-and-clear case, and driving the busy inputs reaches both blocking cases.

// File: rtl/mbox_irq_pkg.sv
// Shared types for the mailbox interrupt controller.
// Assumes: all control strobes are active low and already synchronous to clk.
package mbox_irq_pkg;
    typedef struct packed {
        logic en_n;    // chip enable
        logic we_n;    // 0 = write, 1 = read
        logic oe_n;    // output enable
        logic busy_n;  // arbiter busy
    } port_ctl_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned LFT_IDX   = 0;
    localparam int unsigned RGT_IDX   = 1;
endpackage

// File: rtl/mbox_port_decode.sv
// Per-port access decoder.
// Turns one port's strobes and address into two events:
//   post_peer - a write into the peer's mailbox
//   take_own  - a read of this port's own mailbox
// An active busy suppresses both events.
// Assumes: the strobes are stable around the sampling edge.
module mbox_port_decode
    import mbox_irq_pkg::*;
#(
    parameter int unsigned     AW       = 12,
    parameter logic [AW-1:0]   OWN_BOX  = '1,
    parameter logic [AW-1:0]   PEER_BOX = '0
) (
    input  port_ctl_t          ctl,
    input  logic [AW-1:0]      addr,
    output logic               post_peer,
    output logic               take_own
);
    logic sel;
    logic wr_go;
    logic rd_go;

    // Qualify the access: selected, not held off by the arbiter.
    always_comb begin
        sel   = !ctl.en_n && ctl.busy_n;
        wr_go = sel && !ctl.we_n;
        rd_go = sel && ctl.we_n && !ctl.oe_n;
    end

    // Match the qualified access against the two mailbox addresses.
    always_comb begin
        post_peer = wr_go && (addr == PEER_BOX);
        take_own  = rd_go && (addr == OWN_BOX);
    end
endmodule

// File: rtl/mbox_flag.sv
// One active-low interrupt flag.
// A set drives the flag low and a clear drives it high; set has priority.
// With neither request, the flag holds.
// Assumes: synchronous active-low reset leaves the flag inactive (high).
module mbox_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic flag_n
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_n <= 1'b1;
        else if (set_req)
            flag_n <= 1'b0;
        else if (clr_req)
            flag_n <= 1'b1;
    end

    AST_SET_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        set_req |=> !flag_n);                          // R9
    AST_CLR_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req && !set_req) |=> flag_n);             // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_req && !clr_req) |=> $stable(flag_n));   // R10
    AST_RESET_HIGH: assert property (@(posedge clk)
        !rst_n |=> flag_n);                            // R1
endmodule

// File: rtl/mbox_irq_ctrl.sv
// Mailbox interrupt controller for a two-port memory.
// The all-ones word address is the right mailbox; the address below it
// is the left mailbox. Writing the peer's mailbox raises the peer's
// interrupt, and the owner reading its own mailbox releases it.
// Assumes: port index 0 is left and 1 is right; every strobe is synchronous.
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lft_en_n,
    input  logic          lft_we_n,
    input  logic          lft_oe_n,
    input  logic          lft_busy_n,
    input  logic [AW-1:0] lft_addr,
    input  logic          rgt_en_n,
    input  logic          rgt_we_n,
    input  logic          rgt_oe_n,
    input  logic          rgt_busy_n,
    input  logic [AW-1:0] rgt_addr,
    output logic          lft_irq_n,
    output logic          rgt_irq_n
);
    localparam logic [AW-1:0] RGT_BOX = {AW{1'b1}};
    localparam logic [AW-1:0] LFT_BOX = RGT_BOX - 1'b1;

    port_ctl_t     ctl      [NUM_PORTS];
    logic [AW-1:0] addr     [NUM_PORTS];
    logic          post     [NUM_PORTS];
    logic          take     [NUM_PORTS];
    logic          flag_n   [NUM_PORTS];

    // Gather each port's pins into the shared record.
    always_comb begin
        ctl[LFT_IDX]  = '{en_n: lft_en_n, we_n: lft_we_n, oe_n: lft_oe_n, busy_n: lft_busy_n};
        ctl[RGT_IDX]  = '{en_n: rgt_en_n, we_n: rgt_we_n, oe_n: rgt_oe_n, busy_n: rgt_busy_n};
        addr[LFT_IDX] = lft_addr;
        addr[RGT_IDX] = rgt_addr;
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [AW-1:0] OWN  = (p == LFT_IDX) ? LFT_BOX : RGT_BOX;
        localparam logic [AW-1:0] PEER = (p == LFT_IDX) ? RGT_BOX : LFT_BOX;

        mbox_port_decode #(.AW(AW), .OWN_BOX(OWN), .PEER_BOX(PEER)) u_dec (
            .ctl       (ctl[p]),
            .addr      (addr[p]),
            .post_peer (post[p]),
            .take_own  (take[p])
        );

        // The flag of port p is set by the other port and cleared by p itself.
        mbox_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (post[NUM_PORTS-1-p]),
            .clr_req (take[p]),
            .flag_n  (flag_n[p])
        );
    end

    assign lft_irq_n = flag_n[LFT_IDX];
    assign rgt_irq_n = flag_n[RGT_IDX];

    AST_LBUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !lft_busy_n |=> !$fell(rgt_irq_n));             // R7
    AST_RBUSY_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !rgt_busy_n |=> !$fell(lft_irq_n));             // R7
    AST_LBUSY_NO_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !lft_busy_n |=> !$rose(lft_irq_n));             // R8
    AST_PEER_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_en_n && lft_we_n && !lft_oe_n && lft_addr == RGT_BOX && rgt_en_n)
        |=> !$rose(rgt_irq_n));                         // R6
endmodule

// File: tb/mbox_irq_ctrl_test.sv
`timescale 1ns/1ps
module mbox_irq_ctrl_test;
    localparam int AW = 4;
    localparam int RBOX = 15;
    localparam int LBOX = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en_n = 1, l_we_n = 1, l_oe_n = 1, l_busy_n = 1;
    logic r_en_n = 1, r_we_n = 1, r_oe_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic lft_irq_n, rgt_irq_n;

    int compared = 0;
    int mismatched = 0;
    bit armed = 0;
    string cur_req = "R1";
    int m_l = 1, m_r = 1;   // reference model of the two flags

    always #2.5 clk = ~clk;

    mbox_irq_ctrl #(.AW(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .lft_en_n(l_en_n), .lft_we_n(l_we_n), .lft_oe_n(l_oe_n),
        .lft_busy_n(l_busy_n), .lft_addr(l_addr),
        .rgt_en_n(r_en_n), .rgt_we_n(r_we_n), .rgt_oe_n(r_oe_n),
        .rgt_busy_n(r_busy_n), .rgt_addr(r_addr),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
    );

    // Behavioural reference: evaluated on every rising edge.
    always @(posedge clk) begin
        bit set_r, clr_r, set_l, clr_l;
        set_r = !l_en_n && !l_we_n && l_busy_n && int'(l_addr) == RBOX;
        clr_r = !r_en_n && r_we_n && !r_oe_n && r_busy_n && int'(r_addr) == RBOX;
        set_l = !r_en_n && !r_we_n && r_busy_n && int'(r_addr) == LBOX;
        clr_l = !l_en_n && l_we_n && !l_oe_n && l_busy_n && int'(l_addr) == LBOX;
        if (!rst_n) begin m_l = 1; m_r = 1; end
        else begin
            if (set_r) m_r = 0; else if (clr_r) m_r = 1;
            if (set_l) m_l = 0; else if (clr_l) m_l = 1;
        end
        armed = 1;
    end

    // Compare the outputs against the model on every falling edge.
    always @(negedge clk) begin
        if (armed) begin
            compared++;
            if (lft_irq_n !== m_l[0] || rgt_irq_n !== m_r[0]) begin
                mismatched++;
                $display("FAIL %s model: lft=%b rgt=%b expected %0d %0d",
                         cur_req, lft_irq_n, rgt_irq_n, m_l, m_r);
            end
        end
    end

    task automatic idle();
        {l_en_n, l_we_n, l_oe_n, l_busy_n} = 4'b1111;
        {r_en_n, r_we_n, r_oe_n, r_busy_n} = 4'b1111;
    endtask

    task automatic put_l(input logic en_n, we_n, oe_n, busy_n, input int a);
        {l_en_n, l_we_n, l_oe_n, l_busy_n} = {en_n, we_n, oe_n, busy_n};
        l_addr = AW'(a);
    endtask

    task automatic put_r(input logic en_n, we_n, oe_n, busy_n, input int a);
        {r_en_n, r_we_n, r_oe_n, r_busy_n} = {en_n, we_n, oe_n, busy_n};
        r_addr = AW'(a);
    endtask

    // Hold the driven access for one edge, then return both ports to idle.
    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic expect2(input string tag, input logic el, input logic er);
        compared++;
        if (lft_irq_n !== el || rgt_irq_n !== er) begin
            mismatched++;
            $display("FAIL %s: lft=%b rgt=%b expected %b %b",
                     tag, lft_irq_n, rgt_irq_n, el, er);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        expect2("R1 reset", 1, 1);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R2";
        put_l(0, 0, 1, 1, 13); tick(); expect2("R2 addr below boxes", 1, 1);
        cur_req = "R3";
        put_l(0, 0, 1, 1, RBOX); tick(); expect2("R3 left posts right", 1, 0);
        cur_req = "R6";
        put_l(0, 1, 0, 1, RBOX); tick(); expect2("R6 left reads right box", 1, 0);
        cur_req = "R10";
        put_r(0, 1, 1, 1, RBOX); tick(); expect2("R10 read with oe high", 1, 0);
        put_r(1, 1, 0, 1, RBOX); tick(); expect2("R10 read with en high", 1, 0);
        cur_req = "R8";
        put_r(0, 1, 0, 0, RBOX); tick(); expect2("R8 busy blocks right clear", 1, 0);
        cur_req = "R5";
        put_r(0, 1, 0, 1, RBOX); tick(); expect2("R5 right clears own", 1, 1);
        cur_req = "R4";
        put_r(0, 0, 1, 1, LBOX); tick(); expect2("R4 right posts left", 0, 1);
        cur_req = "R6";
        put_r(0, 1, 0, 1, LBOX); tick(); expect2("R6 right reads left box", 0, 1);
        cur_req = "R8";
        put_l(0, 1, 0, 0, LBOX); tick(); expect2("R8 busy blocks left clear", 0, 1);
        cur_req = "R5";
        put_l(0, 1, 0, 1, LBOX); tick(); expect2("R5 left clears own", 1, 1);
        cur_req = "R7";
        put_l(0, 0, 1, 0, RBOX); tick(); expect2("R7 left busy blocks set", 1, 1);
        put_r(0, 0, 1, 0, LBOX); tick(); expect2("R7 right busy blocks set", 1, 1);
        cur_req = "R10";
        put_r(0, 0, 1, 1, RBOX); put_l(0, 0, 1, 1, LBOX); tick();
        expect2("R10 write to own box", 1, 1);
        put_l(1, 0, 1, 1, RBOX); tick(); expect2("R10 write with en high", 1, 1);

        cur_req = "R9";
        put_l(0, 0, 1, 1, RBOX); put_r(0, 1, 0, 1, RBOX); tick();
        expect2("R9 set wins from idle", 1, 0);
        put_l(0, 0, 1, 1, RBOX); put_r(0, 1, 0, 1, RBOX); tick();
        expect2("R9 set wins while pending", 1, 0);
        put_r(0, 1, 0, 1, RBOX); tick(); expect2("R5 clear after R9", 1, 1);

        cur_req = "R2";
        for (int a = 0; a < 16; a++) begin
            put_l(0, 0, 1, 1, a); tick();
            expect2("R2 left sweep", 1, (a == RBOX) ? 1'b0 : 1'b1);
            put_r(0, 1, 0, 1, RBOX); tick();
            put_r(0, 0, 1, 1, a); tick();
            expect2("R2 right sweep", (a == LBOX) ? 1'b0 : 1'b1, 1);
            put_l(0, 1, 0, 1, LBOX); tick();
        end

        cur_req = "R1";
        put_l(0, 0, 1, 1, RBOX); put_r(0, 0, 1, 1, LBOX); tick();
        expect2("R1 both set before reset", 0, 0);
        rst_n = 0; @(negedge clk);
        expect2("R1 reset clears both", 1, 1);
        rst_n = 1; @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule